// File: doc/BRIEF.md
# Two-Way Framed Message Store

This block sits between two independent processors, called port A and port C, and passes whole messages between them in both directions. Bytes that A writes are queued for C to read, and bytes that C writes are queued for A to read. The two queues are independent, but they share one single-port byte memory. Each queue owns a fixed half of that memory, with its own head and tail pointers. The free space of a queue is the distance between its committed head and its open tail.

A port issues one operation at a time as a single-cycle request, then waits for the grant pulse. The operation code is 0 for read, 1 for write, 2 for commit and 3 for abort. A write appends one payload byte to the port's open outbound message, and nothing of that message is visible to the reader yet. A commit stores the payload length in the byte slot reserved at the start of the message, then publishes the message. An abort discards the open message. On the read side, the first byte returned for a message is its length, the payload follows in order, and the last byte is flagged. The head pointer moves past the whole message only when that last byte is delivered.

Every operation takes one memory slot of two cycles. When both ports compete for a slot, port A wins, so a request never waits for more than one foreign slot. Each port's indicator output is high while its inbound queue holds at least one committed message.

Top module: `qs_msg_store`

## Requirements
- R1: After reset both indicators are low, no grant is asserted, and both queues are empty.
- R2: A message committed by port A is read only by port C, and a message committed by port C is read only by port A.
- R3: A read of a message returns the length byte first, then the payload bytes in write order. The last flag is set only with the final byte. A zero-length message returns a single byte of value 0 with the last flag set.
- R4: The reader's indicator stays low while a message is being written. It rises in the same cycle as the writer's commit grant.
- R5: An abort returns a grant without error and discards every byte written since the last commit. A later commit then publishes only bytes written after the abort.
- R6: With the store idle, a request sampled at clock edge t gets its grant pulse during the cycle after edge t+2. Port A's request wins when both ports request at the same edge, and port C's grant then follows two cycles after port A's.
- R7: Every request is granted no later than the cycle after the fourth clock edge following the one that sampled it.
- R8: Each queue holds 2^(ADDR_W-1) bytes, length bytes included. A write that would leave no room for the message's length byte is refused with the error flag, and the open message is kept. A read of an empty queue is refused with the error flag, and the last flag stays low.
- R9: The reader's indicator falls in the cycle whose grant delivers the last byte of the only committed message.
- R10: The pointers wrap within their half of the memory, so messages that straddle the end of the half read back intact.
- R11: Grants are single-cycle pulses, at most one port is granted in any cycle, and a grant only answers an outstanding request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports and the memory |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Port A request strobe, one cycle |
| a_op | input | 2 | Port A operation: 0 read, 1 write, 2 commit, 3 abort |
| a_wdata | input | DATA_W | Port A payload byte for a write |
| a_gnt | output | 1 | Port A grant pulse |
| a_rdata | output | DATA_W | Byte returned to port A with a read grant |
| a_last | output | 1 | Port A read grant carries the final byte of a message |
| a_err | output | 1 | Port A operation refused |
| a_ind | output | 1 | Queue from C to A holds a committed message |
| c_req | input | 1 | Port C request strobe, one cycle |
| c_op | input | 2 | Port C operation: 0 read, 1 write, 2 commit, 3 abort |
| c_wdata | input | DATA_W | Port C payload byte for a write |
| c_gnt | output | 1 | Port C grant pulse |
| c_rdata | output | DATA_W | Byte returned to port C with a read grant |
| c_last | output | 1 | Port C read grant carries the final byte of a message |
| c_err | output | 1 | Port C operation refused |
| c_ind | output | 1 | Queue from A to C holds a committed message |

## Verification
The assertions assume that each port keeps to the one-outstanding-operation rule. A port raises a request only while it has no request waiting for a grant, and never in the cycle its own grant appears. The latency, priority and grant-pairing properties are only meaningful under that rule. The bench holds to it by driving each request for one cycle and then waiting for the grant before issuing the next. Contention is created only by starting one request on each port in the same cycle.

// File: rtl/qs_pkg.sv
package qs_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_COMMIT = 2'd2,
        OP_ABORT  = 2'd3
    } qs_op_e;

    localparam logic PORT_A = 1'b0;
    localparam logic PORT_C = 1'b1;

endpackage

// File: rtl/qs_ram.sv
module qs_ram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 2 ** AW;

    logic [DW-1:0] mem_q [WORDS];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[addr] <= wdata;
            end
            rdata_q <= mem_q[addr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/qs_queue.sv
module qs_queue
    import qs_pkg::*;
#(
    parameter int QW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  qs_op_e        upd_op,
    input  logic [DW-1:0] upd_byte,
    output logic [QW-1:0] wr_addr,
    output logic [QW-1:0] cm_addr,
    output logic [QW-1:0] rd_addr,
    output logic [DW-1:0] open_len,
    output logic          can_write,
    output logic          can_commit,
    output logic          has_msg,
    output logic          rd_last
);
    localparam int DEPTH = 2 ** QW;
    localparam int PW    = QW + 1;

    typedef struct packed {
        logic [PW-1:0] wr_start;
        logic [DW-1:0] wlen;
        logic [PW-1:0] rd_start;
        logic [DW-1:0] roff;
        logic [DW-1:0] rlen;
    } q_st_t;

    q_st_t st_q, st_d;

    logic [PW-1:0] fill_w;
    logic [PW-1:0] wr_next_w;
    logic [PW-1:0] rd_cur_w;
    logic [PW-1:0] wr_commit_w;
    logic [PW-1:0] rd_done_w;

    always_comb begin
        fill_w      = st_q.wr_start - st_q.rd_start;
        wr_next_w   = st_q.wr_start + PW'(st_q.wlen) + PW'(1);
        rd_cur_w    = st_q.rd_start + PW'(st_q.roff);
        wr_commit_w = st_q.wr_start + PW'(st_q.wlen) + PW'(1);
        rd_done_w   = st_q.rd_start + PW'(st_q.roff) + PW'(1);

        wr_addr    = wr_next_w[QW-1:0];
        cm_addr    = st_q.wr_start[QW-1:0];
        rd_addr    = rd_cur_w[QW-1:0];
        open_len   = st_q.wlen;
        has_msg    = (st_q.wr_start != st_q.rd_start);
        can_write  = (int'(fill_w) + int'(st_q.wlen) + 2 <= DEPTH) && (st_q.wlen != '1);
        can_commit = (int'(fill_w) + int'(st_q.wlen) + 1 <= DEPTH);

        if (st_q.roff == '0) begin
            rd_last = (upd_byte == '0);
        end else begin
            rd_last = (st_q.roff == st_q.rlen);
        end

        st_d = st_q;
        if (upd_en) begin
            unique case (upd_op)
                OP_WRITE: begin
                    st_d.wlen = st_q.wlen + DW'(1);
                end
                OP_COMMIT: begin
                    st_d.wr_start = wr_commit_w;
                    st_d.wlen     = '0;
                end
                OP_ABORT: begin
                    st_d.wlen = '0;
                end
                OP_READ: begin
                    if (st_q.roff == '0) begin
                        st_d.rlen = upd_byte;
                    end
                    if (rd_last) begin
                        st_d.rd_start = rd_done_w;
                        st_d.roff     = '0;
                    end else begin
                        st_d.roff = st_q.roff + DW'(1);
                    end
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/qs_arbiter.sv
module qs_arbiter
    import qs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_req,
    input  qs_op_e        a_op,
    input  logic [DW-1:0] a_wdata,
    input  logic          c_req,
    input  qs_op_e        c_op,
    input  logic [DW-1:0] c_wdata,
    input  logic          iss_ok,
    output logic          iss_valid,
    output logic          iss_port,
    output qs_op_e        iss_op,
    output logic [DW-1:0] iss_wdata,
    output logic          rsp_valid,
    output logic          rsp_port,
    output qs_op_e        rsp_op,
    output logic          rsp_ok
);
    typedef struct packed {
        logic          a_pend;
        qs_op_e        a_op;
        logic [DW-1:0] a_wd;
        logic          c_pend;
        qs_op_e        c_op;
        logic [DW-1:0] c_wd;
        logic          busy;
        logic          r_port;
        qs_op_e        r_op;
        logic          r_ok;
    } arb_st_t;

    arb_st_t st_q, st_d;

    always_comb begin
        iss_valid = !st_q.busy && (st_q.a_pend || st_q.c_pend);
        iss_port  = st_q.a_pend ? PORT_A : PORT_C;
        iss_op    = st_q.a_pend ? st_q.a_op : st_q.c_op;
        iss_wdata = st_q.a_pend ? st_q.a_wd : st_q.c_wd;

        rsp_valid = st_q.busy;
        rsp_port  = st_q.r_port;
        rsp_op    = st_q.r_op;
        rsp_ok    = st_q.r_ok;

        st_d      = st_q;
        st_d.busy = iss_valid;
        if (iss_valid) begin
            st_d.r_port = iss_port;
            st_d.r_op   = iss_op;
            st_d.r_ok   = iss_ok;
            if (iss_port == PORT_A) begin
                st_d.a_pend = 1'b0;
            end else begin
                st_d.c_pend = 1'b0;
            end
        end
        if (a_req && !st_q.a_pend) begin
            st_d.a_pend = 1'b1;
            st_d.a_op   = a_op;
            st_d.a_wd   = a_wdata;
        end
        if (c_req && !st_q.c_pend) begin
            st_d.c_pend = 1'b1;
            st_d.c_op   = c_op;
            st_d.c_wd   = c_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/qs_msg_store.sv
module qs_msg_store
    import qs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic [1:0]        a_op,
    input  logic [DATA_W-1:0] a_wdata,
    output logic              a_gnt,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_last,
    output logic              a_err,
    output logic              a_ind,
    input  logic              c_req,
    input  logic [1:0]        c_op,
    input  logic [DATA_W-1:0] c_wdata,
    output logic              c_gnt,
    output logic [DATA_W-1:0] c_rdata,
    output logic              c_last,
    output logic              c_err,
    output logic              c_ind
);
    localparam int QW = ADDR_W - 1;
    localparam int NQ = 2;

    typedef struct packed {
        logic              a_gnt;
        logic [DATA_W-1:0] a_rdata;
        logic              a_last;
        logic              a_err;
        logic              c_gnt;
        logic [DATA_W-1:0] c_rdata;
        logic              c_last;
        logic              c_err;
    } out_st_t;

    out_st_t out_q, out_d;

    logic              iss_valid, iss_port, iss_ok;
    qs_op_e            iss_op;
    logic [DATA_W-1:0] iss_wdata;
    logic              rsp_valid, rsp_port, rsp_ok;
    qs_op_e            rsp_op;
    logic              iss_q, rsp_q;

    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    logic [NQ-1:0]     q_upd_en, q_can_write, q_can_commit, q_has_msg, q_rd_last;
    logic [QW-1:0]     q_wr_addr [NQ];
    logic [QW-1:0]     q_cm_addr [NQ];
    logic [QW-1:0]     q_rd_addr [NQ];
    logic [DATA_W-1:0] q_open_len [NQ];

    qs_arbiter #(.DW(DATA_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_req     (a_req),
        .a_op      (qs_op_e'(a_op)),
        .a_wdata   (a_wdata),
        .c_req     (c_req),
        .c_op      (qs_op_e'(c_op)),
        .c_wdata   (c_wdata),
        .iss_ok    (iss_ok),
        .iss_valid (iss_valid),
        .iss_port  (iss_port),
        .iss_op    (iss_op),
        .iss_wdata (iss_wdata),
        .rsp_valid (rsp_valid),
        .rsp_port  (rsp_port),
        .rsp_op    (rsp_op),
        .rsp_ok    (rsp_ok)
    );

    for (genvar gi = 0; gi < NQ; gi++) begin : g_queue
        qs_queue #(.QW(QW), .DW(DATA_W)) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .upd_en     (q_upd_en[gi]),
            .upd_op     (rsp_op),
            .upd_byte   (mem_rdata),
            .wr_addr    (q_wr_addr[gi]),
            .cm_addr    (q_cm_addr[gi]),
            .rd_addr    (q_rd_addr[gi]),
            .open_len   (q_open_len[gi]),
            .can_write  (q_can_write[gi]),
            .can_commit (q_can_commit[gi]),
            .has_msg    (q_has_msg[gi]),
            .rd_last    (q_rd_last[gi])
        );
    end

    qs_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        // queue index: writer's port for write-side ops, the other port for reads
        iss_q = iss_port ^ (iss_op == OP_READ);
        rsp_q = rsp_port ^ (rsp_op == OP_READ);

        unique case (iss_op)
            OP_READ:   iss_ok = q_has_msg[iss_q];
            OP_WRITE:  iss_ok = q_can_write[iss_q];
            OP_COMMIT: iss_ok = q_can_commit[iss_q];
            default:   iss_ok = 1'b1;
        endcase

        mem_en    = iss_valid && iss_ok && (iss_op != OP_ABORT);
        mem_we    = (iss_op == OP_WRITE) || (iss_op == OP_COMMIT);
        mem_wdata = (iss_op == OP_WRITE) ? iss_wdata : q_open_len[iss_q];
        unique case (iss_op)
            OP_WRITE:  mem_addr = {iss_q, q_wr_addr[iss_q]};
            OP_COMMIT: mem_addr = {iss_q, q_cm_addr[iss_q]};
            default:   mem_addr = {iss_q, q_rd_addr[iss_q]};
        endcase

        for (int i = 0; i < NQ; i++) begin
            q_upd_en[i] = rsp_valid && rsp_ok && (rsp_q == 1'(i));
        end

        out_d = '0;
        if (rsp_valid) begin
            if (rsp_port == PORT_A) begin
                out_d.a_gnt = 1'b1;
                out_d.a_err = !rsp_ok;
                if (rsp_ok && rsp_op == OP_READ) begin
                    out_d.a_rdata = mem_rdata;
                    out_d.a_last  = q_rd_last[rsp_q];
                end
            end else begin
                out_d.c_gnt = 1'b1;
                out_d.c_err = !rsp_ok;
                if (rsp_ok && rsp_op == OP_READ) begin
                    out_d.c_rdata = mem_rdata;
                    out_d.c_last  = q_rd_last[rsp_q];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign a_gnt   = out_q.a_gnt;
    assign a_rdata = out_q.a_rdata;
    assign a_last  = out_q.a_last;
    assign a_err   = out_q.a_err;
    assign c_gnt   = out_q.c_gnt;
    assign c_rdata = out_q.c_rdata;
    assign c_last  = out_q.c_last;
    assign c_err   = out_q.c_err;
    assign a_ind   = q_has_msg[1];
    assign c_ind   = q_has_msg[0];
endmodule

// File: rtl/qs_msg_store_chk.sv
module qs_msg_store_chk (
    input logic clk,
    input logic rst_n,
    input logic a_req,
    input logic c_req,
    input logic a_gnt,
    input logic c_gnt,
    input logic a_last,
    input logic c_last,
    input logic a_err,
    input logic c_err,
    input logic a_ind,
    input logic c_ind
);
    localparam int WAIT_MAX = 4;

    logic       a_out_q, c_out_q, a_tie_q;
    logic [3:0] a_wait_q, c_wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_out_q  <= 1'b0;
            c_out_q  <= 1'b0;
            a_tie_q  <= 1'b0;
            a_wait_q <= '0;
            c_wait_q <= '0;
        end else begin
            if (a_req && !a_out_q) begin
                a_out_q  <= 1'b1;
                a_wait_q <= '0;
            end else if (a_gnt) begin
                a_out_q  <= 1'b0;
                a_wait_q <= '0;
            end else if (a_out_q && a_wait_q != '1) begin
                a_wait_q <= a_wait_q + 4'd1;
            end
            if (c_req && !c_out_q) begin
                c_out_q  <= 1'b1;
                c_wait_q <= '0;
            end else if (c_gnt) begin
                c_out_q  <= 1'b0;
                c_wait_q <= '0;
            end else if (c_out_q && c_wait_q != '1) begin
                c_wait_q <= c_wait_q + 4'd1;
            end
            if (a_req && c_req && !a_out_q && !c_out_q) begin
                a_tie_q <= 1'b1;
            end else if (a_gnt) begin
                a_tie_q <= 1'b0;
            end
        end
    end

    a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_gnt && c_gnt));
    a_r11_a_answers_req: assert property (@(posedge clk) disable iff (!rst_n)
        a_gnt |-> a_out_q);
    a_r11_c_answers_req: assert property (@(posedge clk) disable iff (!rst_n)
        c_gnt |-> c_out_q);
    a_r11_a_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        a_gnt |=> !a_gnt);
    a_r6_a_first_on_tie: assert property (@(posedge clk) disable iff (!rst_n)
        c_gnt |-> !a_tie_q);
    a_r7_a_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(a_wait_q) <= WAIT_MAX);
    a_r7_c_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(c_wait_q) <= WAIT_MAX);
    a_r4_c_ind_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_ind) |-> a_gnt);
    a_r4_a_ind_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_ind) |-> c_gnt);
    a_r9_c_ind_falls_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_ind) |-> (c_gnt && c_last));
    a_r9_a_ind_falls_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_ind) |-> (a_gnt && a_last));
    a_r8_a_last_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        a_last |-> (a_gnt && !a_err));
    a_r8_c_last_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        c_last |-> (c_gnt && !c_err));
endmodule

bind qs_msg_store qs_msg_store_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_req  (a_req),
    .c_req  (c_req),
    .a_gnt  (a_gnt),
    .c_gnt  (c_gnt),
    .a_last (a_last),
    .c_last (c_last),
    .a_err  (a_err),
    .c_err  (c_err),
    .a_ind  (a_ind),
    .c_ind  (c_ind)
);

// File: tb/tb_qs_msg_store.sv
`timescale 1ns/1ps
module tb_qs_msg_store;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int HALF = 2 ** (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_req = 1'b0, c_req = 1'b0;
    logic [1:0]    a_op = 2'd0, c_op = 2'd0;
    logic [DW-1:0] a_wdata = '0, c_wdata = '0;
    logic          a_gnt, a_last, a_err, a_ind;
    logic          c_gnt, c_last, c_err, c_ind;
    logic [DW-1:0] a_rdata, c_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qs_msg_store #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_op(a_op), .a_wdata(a_wdata),
        .a_gnt(a_gnt), .a_rdata(a_rdata), .a_last(a_last), .a_err(a_err), .a_ind(a_ind),
        .c_req(c_req), .c_op(c_op), .c_wdata(c_wdata),
        .c_gnt(c_gnt), .c_rdata(c_rdata), .c_last(c_last), .c_err(c_err), .c_ind(c_ind)
    );

    // vector: {port, op, wdata, err, rdata, last, a_ind, c_ind, pad}
    function automatic logic [23:0] vec(input bit p, input logic [1:0] op, input logic [7:0] wd,
                                        input bit er, input logic [7:0] rd, input bit ls,
                                        input bit ai, input bit ci);
        return {p, op, wd, er, rd, ls, ai, ci, 1'b0};
    endfunction

    localparam int NV = 20;
    localparam logic [23:0] VT [NV] = '{
        vec(0, 2'd0, 8'h00, 1, 8'h00, 0, 0, 0),  // R8 read empty
        vec(0, 2'd1, 8'h11, 0, 8'h00, 0, 0, 0),  // R4 open message invisible
        vec(0, 2'd1, 8'h22, 0, 8'h00, 0, 0, 0),
        vec(0, 2'd2, 8'h00, 0, 8'h00, 0, 0, 1),  // R4 commit publishes
        vec(1, 2'd0, 8'h00, 0, 8'h02, 0, 0, 1),  // R3 length first
        vec(1, 2'd0, 8'h00, 0, 8'h11, 0, 0, 1),
        vec(1, 2'd0, 8'h00, 0, 8'h22, 1, 0, 0),  // R9 ind falls with last
        vec(1, 2'd0, 8'h00, 1, 8'h00, 0, 0, 0),  // R8 read empty
        vec(1, 2'd1, 8'h5A, 0, 8'h00, 0, 0, 0),
        vec(1, 2'd3, 8'h00, 0, 8'h00, 0, 0, 0),  // R5 abort
        vec(1, 2'd2, 8'h00, 0, 8'h00, 0, 1, 0),
        vec(0, 2'd0, 8'h00, 0, 8'h00, 1, 0, 0),  // R5 R3 zero length
        vec(1, 2'd1, 8'h77, 0, 8'h00, 0, 0, 0),
        vec(1, 2'd2, 8'h00, 0, 8'h00, 0, 1, 0),
        vec(0, 2'd1, 8'h33, 0, 8'h00, 0, 1, 0),
        vec(0, 2'd2, 8'h00, 0, 8'h00, 0, 1, 1),
        vec(0, 2'd0, 8'h00, 0, 8'h01, 0, 1, 1),  // R2 C to A
        vec(0, 2'd0, 8'h00, 0, 8'h77, 1, 0, 1),
        vec(1, 2'd0, 8'h00, 0, 8'h01, 0, 0, 1),  // R2 A to C
        vec(1, 2'd0, 8'h00, 0, 8'h33, 1, 0, 0)
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit p, input logic [1:0] op, input logic [7:0] wd,
                         output logic [7:0] rd, output logic ls, output logic er,
                         output bit got);
        @(negedge clk);
        if (!p) begin a_req = 1'b1; a_op = op; a_wdata = wd; end
        else    begin c_req = 1'b1; c_op = op; c_wdata = wd; end
        @(negedge clk);
        a_req = 1'b0;
        c_req = 1'b0;
        got = 1'b0;
        rd = '0; ls = 1'b0; er = 1'b0;
        for (int i = 0; i < 12 && !got; i++) begin
            if (!p && a_gnt) begin
                got = 1'b1; rd = a_rdata; ls = a_last; er = a_err;
            end else if (p && c_gnt) begin
                got = 1'b1; rd = c_rdata; ls = c_last; er = c_err;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic       ls, er;
        bit         got;
        int         ka, kc;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 a_ind", a_ind, 0);
        check("R1 c_ind", c_ind, 0);
        check("R1 a_gnt", a_gnt, 0);
        check("R1 c_gnt", c_gnt, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle a_gnt", a_gnt, 0);
        check("R1 idle c_gnt", c_gnt, 0);

        // table walk: R2 R3 R4 R5 R8 R9
        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            e = VT[v];
            do_op(e[23], e[22:21], e[20:13], rd, ls, er, got);
            check($sformatf("R11 vec%0d grant", v), got, 1);
            check($sformatf("R8 vec%0d err", v), er, e[12]);
            if (e[22:21] == 2'd0) begin
                check($sformatf("R3 vec%0d rdata", v), rd, e[11:4]);
            end
            check($sformatf("R3 vec%0d last", v), ls, e[3]);
            check($sformatf("R4 vec%0d a_ind", v), a_ind, e[2]);
            check($sformatf("R4 vec%0d c_ind", v), c_ind, e[1]);
        end

        // R6 R7 R11: simultaneous requests, A first, fixed slot timing
        @(negedge clk);
        a_req = 1'b1; a_op = 2'd1; a_wdata = 8'hA1;
        c_req = 1'b1; c_op = 2'd1; c_wdata = 8'hC1;
        ka = 0; kc = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            a_req = 1'b0; c_req = 1'b0;
            if (a_gnt && c_gnt) check("R11 both granted", 1, 0);
            if (a_gnt && ka == 0) ka = k;
            if (c_gnt && kc == 0) kc = k;
        end
        check("R6 A grant cycle", ka, 3);
        check("R6 C grant cycle", kc, 5);
        check("R7 C within bound", int'(kc > 0 && kc <= 5), 1);
        do_op(0, 2'd3, 8'h00, rd, ls, er, got);
        check("R5 A abort ok", er, 0);
        do_op(1, 2'd3, 8'h00, rd, ls, er, got);
        check("R5 C abort ok", er, 0);
        check("R5 no message after abort", c_ind, 0);

        // R8 R10: fill queue A->C to capacity, pointers wrap inside the half
        for (int i = 0; i < HALF - 1; i++) begin
            do_op(0, 2'd1, 8'(i + 1), rd, ls, er, got);
            check($sformatf("R8 fill byte %0d", i), er, 0);
        end
        do_op(0, 2'd1, 8'hEE, rd, ls, er, got);
        check("R8 overflow refused", er, 1);
        check("R4 still invisible", c_ind, 0);
        do_op(0, 2'd2, 8'h00, rd, ls, er, got);
        check("R8 commit of full message", er, 0);
        check("R4 visible after commit", c_ind, 1);
        do_op(1, 2'd0, 8'h00, rd, ls, er, got);
        check("R10 length of wrapped message", rd, HALF - 1);
        for (int i = 0; i < HALF - 1; i++) begin
            do_op(1, 2'd0, 8'h00, rd, ls, er, got);
            check($sformatf("R10 payload %0d", i), rd, i + 1);
            check($sformatf("R3 last flag %0d", i), ls, int'(i == HALF - 2));
        end
        check("R9 queue drained", c_ind, 0);
        do_op(1, 2'd0, 8'h00, rd, ls, er, got);
        check("R8 empty after drain", er, 1);

        finish_run();
    end
endmodule